// File: doc/BRIEF.md
# Oscillator Sub-Band Calibration Controller

This controller picks one of 32 capacitor-bank sub-bands for an integrated oscillator before the phase-locked loop is closed. Software raises a start bit. On the rising edge of that bit the controller turns the charge pump off and asks the analog side to hold the tuning node at mid-supply. It then runs a binary search over the 5-bit band code, one trial per reference period, and ends with the band whose mid-supply frequency is closest to the target N·Fref/R.

Each trial compares two single-cycle strobes. One marks the edges of the divided reference clock, and each reference period is one measurement window. The other marks the edges of the divided feedback clock. The feedback divider is set so that, at the target frequency, `FB_PER_REF` feedback strobes arrive in one reference period. If the window collects at least that many, the oscillator runs too fast and the trial bit is kept. A higher code adds capacitance and so lowers the frequency. One settle period comes before the first trial and one finish period after the last, so a full run takes 7 reference edges. At the end an active-low done flag falls and the charge pump is enabled again.

An init bit clears the machine. The result stays on the band-code output for read-back until the next init or start edge.

Top module: `vcocal_ctrl`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `cal_init` high, `band_code` is 0, `cal_done_n` is 1, `cp_enable` is 1 and `vtune_hold` is 0. Asserting `cal_init` during a calibration aborts it.
- R2: A calibration starts only on a 0-to-1 change of `cal_start`. Keeping `cal_start` high after completion starts nothing new.
- R3: From the cycle after an accepted start edge until the done flag falls, `cp_enable` is 0, `vtune_hold` is 1 and `cal_done_n` is 1. In every other cycle `cp_enable` is 1 and `vtune_hold` is 0.
- R4: In the cycle after an accepted start edge, `band_code` shows only its MSB set (16 for a 5-bit code). The search then proceeds from the MSB down to the LSB.
- R5: The final code is the largest code whose window holds at least `FB_PER_REF` feedback strobes, taking the frequency to fall as the code rises. If no code qualifies, the result is 0. If every code qualifies, the result is 31.
- R6: `cal_done_n` falls in the cycle after the 7th `ref_edge` strobe that follows the start edge. The 7 strobes are one settle, five trial bits and one finish.
- R7: Once `cal_done_n` is 0, it stays 0 and `band_code` stays unchanged until `cal_init` is raised or a new start edge arrives. A new start edge sets `cal_done_n` back to 1.
- R8: A start edge that arrives while a calibration is running is ignored. Completion timing and result are those of the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_init | input | 1 | Machine clear; holds the idle state while high |
| cal_start | input | 1 | Start bit; its rising edge launches a calibration |
| ref_edge | input | 1 | One-cycle strobe per divided reference edge |
| fb_edge | input | 1 | One-cycle strobe per divided feedback edge |
| band_code | output | CODE_W | Trial code while running, selected sub-band afterwards |
| cal_done_n | output | 1 | Active-low end-of-calibration flag |
| cp_enable | output | 1 | Charge pump enable, low while calibrating |
| vtune_hold | output | 1 | Request to force the tuning node to mid-supply |

## Verification
A wrong internal state shows up within one reference period. A bit decided with the wrong polarity, or a trial mask shifted out of step, drives `band_code` away from the expected sub-band at the same `ref_edge` strobe. A state register that skips or repeats a phase moves the falling edge of `cal_done_n` off the 7th reference strobe. A stale window count either flips a trial decision or is exposed when the charge-pump enable and mid-supply hold drop at the wrong cycle. The stimulus side models the oscillator as a feedback strobe whose period depends on the live band code, with a randomly placed crossover code, so that each decision affects the next trial.

// File: rtl/vcocal_pkg.sv
package vcocal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_TRIAL  = 3'd2,
    ST_FINISH = 3'd3,
    ST_DONE   = 3'd4
  } cal_state_e;
endpackage

// File: rtl/vcocal_edge.sv
module vcocal_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/vcocal_window.sv
module vcocal_window #(
  parameter int FB_PER_REF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic ref_edge_i,
  input  logic fb_edge_i,
  output logic fast_o
);
  localparam int CNT_W = $clog2(FB_PER_REF + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FB_PER_REF);

  logic [CNT_W-1:0] cnt;

  // saturating feedback-edge count, restarted at every window boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear_i) begin
      cnt <= '0;
    end else if (ref_edge_i) begin
      cnt <= fb_edge_i ? CNT_W'(1) : '0;
    end else if (fb_edge_i && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign fast_o = (cnt == CNT_MAX);
endmodule

// File: rtl/vcocal_sar.sv
module vcocal_sar
  import vcocal_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              go_i,
  input  logic              ref_edge_i,
  input  logic              fast_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              done_n_o
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  cal_state_e        state;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] mask;
  logic [CODE_W-1:0] next_code;
  logic              done_n;

  // keep trial bit when oscillator is too fast, then raise the next lower bit
  always_comb begin
    next_code = (fast_i ? code : (code & ~mask)) | (mask >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      code   <= '0;
      mask   <= '0;
      done_n <= 1'b1;
    end else if (init_i) begin
      state  <= ST_IDLE;
      code   <= '0;
      mask   <= '0;
      done_n <= 1'b1;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (go_i) begin
            state  <= ST_SETTLE;
            code   <= MSB_ONLY;
            mask   <= MSB_ONLY;
            done_n <= 1'b1;
          end
        end
        ST_SETTLE: begin
          if (ref_edge_i) state <= ST_TRIAL;
        end
        ST_TRIAL: begin
          if (ref_edge_i) begin
            code <= next_code;
            mask <= mask >> 1;
            if (mask[0]) state <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          if (ref_edge_i) begin
            state  <= ST_DONE;
            done_n <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign code_o   = code;
  assign done_n_o = done_n;
  assign busy_o   = (state == ST_SETTLE) || (state == ST_TRIAL) || (state == ST_FINISH);
endmodule

// File: rtl/vcocal_ctrl.sv
module vcocal_ctrl #(
  parameter int CODE_W     = 5,
  parameter int FB_PER_REF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_init,
  input  logic              cal_start,
  input  logic              ref_edge,
  input  logic              fb_edge,
  output logic [CODE_W-1:0] band_code,
  output logic              cal_done_n,
  output logic              cp_enable,
  output logic              vtune_hold
);
  logic start_rise;
  logic busy;
  logic go;
  logic fast;

  vcocal_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (cal_start),
    .rise_o  (start_rise)
  );

  // a start edge during a run is dropped
  assign go = start_rise & ~busy & ~cal_init;

  vcocal_window #(.FB_PER_REF(FB_PER_REF)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (go | cal_init),
    .ref_edge_i (ref_edge),
    .fb_edge_i  (fb_edge),
    .fast_o     (fast)
  );

  vcocal_sar #(.CODE_W(CODE_W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (cal_init),
    .go_i       (go),
    .ref_edge_i (ref_edge),
    .fast_i     (fast),
    .code_o     (band_code),
    .busy_o     (busy),
    .done_n_o   (cal_done_n)
  );

  assign cp_enable  = ~busy;
  assign vtune_hold = busy;
endmodule

// File: rtl/vcocal_ctrl_chk.sv
module vcocal_ctrl_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_init,
  input logic              cal_start,
  input logic              ref_edge,
  input logic [CODE_W-1:0] band_code,
  input logic              cal_done_n,
  input logic              cp_enable
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_init |=> (band_code == '0 && cal_done_n && cp_enable));

  // R3
  pump_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_enable |-> cal_done_n);

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cp_enable) |-> (band_code == MSB_ONLY));

  // R6
  done_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_done_n) |-> ($past(ref_edge) && cp_enable));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_done_n && !cal_init && !cal_start) |=> (!cal_done_n && $stable(band_code)));
endmodule

bind vcocal_ctrl vcocal_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cal_init   (cal_init),
  .cal_start  (cal_start),
  .ref_edge   (ref_edge),
  .band_code  (band_code),
  .cal_done_n (cal_done_n),
  .cp_enable  (cp_enable)
);

// File: tb/vcocal_ctrl_tb.sv
module vcocal_ctrl_tb;
  localparam int CODE_W = 5;
  localparam int FBR    = 4;
  localparam int RP     = 40;  // reference period in clk cycles
  localparam int P_FAST = 6;   // >= 6 strobes per window
  localparam int P_SLOW = 14;  // <= 3 strobes per window

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_init = 1'b0;
  logic cal_start = 1'b0;
  logic ref_edge = 1'b0;
  logic fb_edge = 1'b0;
  logic [CODE_W-1:0] band_code;
  logic cal_done_n, cp_enable, vtune_hold;

  int n_tests = 0;
  int n_fail = 0;
  int thr = -1;
  int ref_div = 0;
  int fb_div = 0;
  int refs_seen = 0;

  always #10 clk = ~clk;

  vcocal_ctrl #(.CODE_W(CODE_W), .FB_PER_REF(FBR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_init(cal_init), .cal_start(cal_start),
    .ref_edge(ref_edge), .fb_edge(fb_edge), .band_code(band_code),
    .cal_done_n(cal_done_n), .cp_enable(cp_enable), .vtune_hold(vtune_hold)
  );

  // behavioural oscillator and dividers, driven away from the active edge
  always @(negedge clk) begin
    if (ref_div == RP - 1) begin ref_div = 0; ref_edge = 1'b1; end
    else begin ref_div = ref_div + 1; ref_edge = 1'b0; end
    fb_div = fb_div + 1;
    if (fb_div >= ((int'(band_code) <= thr) ? P_FAST : P_SLOW)) begin
      fb_div = 0; fb_edge = 1'b1;
    end else begin
      fb_edge = 1'b0;
    end
  end

  always @(posedge clk) if (ref_edge) refs_seen <= refs_seen + 1;

  function automatic int exp_code(input int k);
    if (k < 0) return 0;
    if (k > 31) return 31;
    return k;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run(input int k);
    int waited = 0;
    while (cal_done_n && waited < 20 * RP) begin
      if (waited > 0) chk(!cp_enable && vtune_hold, "R3 pump off while running", cp_enable, 0);
      @(negedge clk);
      waited++;
    end
    chk(cal_done_n == 1'b0, "R6 done flag fell", cal_done_n, 0);
    chk(refs_seen == 7, "R6 seven reference periods", refs_seen, 7);
    chk(int'(band_code) == exp_code(k), "R5 selected band", band_code, exp_code(k));
    chk(cp_enable && !vtune_hold, "R3 pump back on", cp_enable, 1);
  endtask

  task automatic launch(input int k);
    thr = k;
    @(negedge clk);
    cal_start = 1'b1;
    refs_seen = ref_edge ? -1 : 0;
    @(negedge clk);
    chk(band_code == 5'd16, "R4 MSB trial first", band_code, 16);
    chk(!cp_enable && vtune_hold && cal_done_n, "R3 busy outputs", cp_enable, 0);
  endtask

  task automatic run_cal(input int k);
    launch(k);
    finish_run(k);
    @(negedge clk);
    cal_start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(band_code == 0 && cal_done_n && cp_enable && !vtune_hold, "R1 reset state", band_code, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(band_code == 0 && cal_done_n && cp_enable, "R1 idle after reset", cal_done_n, 1);

    // directed corners for R5
    run_cal(-1);
    run_cal(31);
    run_cal(15);
    run_cal(16);
    run_cal(0);

    // random crossover codes, R5
    for (int i = 0; i < 8; i++) run_cal(int'($urandom_range(0, 31)));

    // R2 and R7: level held high after completion starts nothing
    begin
      int held;
      launch(9);
      finish_run(9);
      held = int'(band_code);
      repeat (10 * RP) @(negedge clk);
      chk(!cal_done_n && int'(band_code) == held, "R2 held start ignored", band_code, held);
      chk(cp_enable, "R7 result kept", cp_enable, 1);
      cal_start = 1'b0;
      repeat (2 * RP) @(negedge clk);
      chk(!cal_done_n && int'(band_code) == held, "R7 done stays low", cal_done_n, 0);
    end

    // R7 new start edge raises the flag again
    launch(22);
    chk(cal_done_n == 1'b1, "R7 new start raises flag", cal_done_n, 1);
    finish_run(22);
    @(negedge clk); cal_start = 1'b0; @(negedge clk);

    // R8 restrike during a run
    launch(5);
    @(negedge clk); cal_start = 1'b0;
    while (refs_seen < 3) @(negedge clk);
    cal_start = 1'b1;
    @(negedge clk);
    chk(!cp_enable && int'(band_code) != 16, "R8 restrike no restart", band_code, 0);
    finish_run(5);
    @(negedge clk); cal_start = 1'b0; @(negedge clk);

    // R1 init aborts a run
    launch(20);
    while (refs_seen < 2) @(negedge clk);
    cal_init = 1'b1;
    repeat (3) @(negedge clk);
    chk(band_code == 0 && cal_done_n && cp_enable && !vtune_hold, "R1 init aborts", band_code, 0);
    cal_init = 1'b0;
    repeat (2 * RP) @(negedge clk);
    chk(band_code == 0 && cal_done_n && cp_enable, "R1 stays idle after init", cp_enable, 1);
    cal_start = 1'b0;
    @(negedge clk);

    // R1 init after completion clears the flag
    run_cal(27);
    cal_init = 1'b1;
    @(negedge clk);
    cal_init = 1'b0;
    @(negedge clk);
    chk(band_code == 0 && cal_done_n == 1'b1, "R1 init after done", cal_done_n, 1);
    run_cal(3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule